// File: doc/BRIEF.md
# VGA access SMI trap decoder

This block monitors the processor's memory and I/O bus cycles. When software touches a legacy VGA resource, it raises a system-management interrupt request. There are two kinds of trap. The first is a memory write into one of the three display segments. The second is any I/O read or write to one of the three VGA port blocks. Memory reads are never trapped.

Each trapped range has its own enable bit. A 32-bit window mask can exclude individual 2 KB windows of the A-segment. This keeps accesses to off-screen buffers from interrupting the processor.

Each qualifying access produces a one-clock request pulse in the following cycle. It also records a cause code that stays put until software clears it. Software reaches the control register, the mask register and the cause-clear action through a simple write port.

Top module: `vga_smi_trap`

## Requirements
- R1: A valid memory write (`bus_is_io_i`=0, `bus_write_i`=1) to 0xA0000–0xAFFFF, 0xB0000–0xB7FFF or 0xB8000–0xBFFFF, with that range enabled, drives `smi_req_o` high for exactly one clock, in the cycle after the access.
- R2: A memory read (`bus_is_io_i`=0, `bus_write_i`=0) never raises `smi_req_o`, whatever its address.
- R3: A valid I/O access (`bus_is_io_i`=1), read or write, to ports 0x3B0–0x3BF, 0x3C0–0x3CF or 0x3D0–0x3DF, with that range enabled, raises the request pulse. A memory write to those same addresses does not.
- R4: Control register bits [5:0] enable, in order: A-segment, 0xB0000 range, 0xB8000 range, 0x3Bx ports, 0x3Cx ports, 0x3Dx ports. A hit in a range whose bit is 0 raises no request.
- R5: When mask bit n is 1, memory writes to 0xA0000 + n×0x800 through 0xA0000 + n×0x800 + 0x7FF raise no request. Neighbouring windows whose bits are 0 still trap.
- R6: The mask has no effect on any range other than the A-segment. With the A-segment enable cleared, A-segment writes raise no request for any mask value.
- R7: On each request, `cause_o` takes the code of the range hit: 1 A-segment, 2 0xB0000, 3 0xB8000, 4 0x3Bx, 5 0x3Cx, 6 0x3Dx. It keeps that value through later non-trapping cycles, and a later trap overwrites it.
- R8: A config write with `cfg_sel_i`=2 clears `cause_o` to 0 in the next cycle. If a trap occurs in the same cycle, the new cause code is loaded instead of 0.
- R9: A memory access with any of address bits [31:20] set, or an I/O access with any of bits [31:16] set, raises no request.
- R10: Qualifying accesses in consecutive cycles each produce their own pulse, so `smi_req_o` stays high across both cycles, with `cause_o` following each one.
- R11: After reset, `smi_req_o` is 0, `cause_o` is 0, all enables are clear and all mask bits are clear. A config write with `cfg_sel_i`=0 loads the enables and one with `cfg_sel_i`=1 loads the mask; each takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus cycle valid strobe |
| bus_addr_i | input | 32 | Bus cycle address |
| bus_is_io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | 0 control, 1 mask, 2 clear cause |
| cfg_wdata_i | input | 32 | Config write data |
| smi_req_o | output | 1 | One-clock SMI request pulse |
| cause_o | output | 3 | Sticky cause code |

## Verification
Two functions can land in the same cycle: a software clear of the cause register and a new qualifying trap. The bench provokes this by asserting the clear write and a trapping bus access together. It then judges that, one cycle later, the pulse is present and the cause holds the new code, not zero. A second pairing places a back-to-back trap in the cycle right after an earlier one. The bench checks that the pulse stays high and that the cause changes to the second range's code.

// File: rtl/vga_smi_pkg.sv
package vga_smi_pkg;
  localparam int unsigned NUM_RANGES = 6;
  localparam int unsigned CAUSE_W    = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_ASEG = 3'd1,
    CAUSE_B0   = 3'd2,
    CAUSE_B8   = 3'd3,
    CAUSE_P3B  = 3'd4,
    CAUSE_P3C  = 3'd5,
    CAUSE_P3D  = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CLR  = 2'd2
  } cfg_sel_e;

  // hit vector bit positions; bit i maps to cause code i+1
  localparam int unsigned HIT_ASEG = 0;
endpackage

// File: rtl/vga_smi_decode.sv
module vga_smi_decode
  import vga_smi_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 32
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      is_io_i,
  input  logic                      write_i,
  output logic [NUM_RANGES-1:0]     hit_o,
  output logic [$clog2(MASK_W)-1:0] win_o
);
  localparam int unsigned WIN_W   = $clog2(MASK_W);
  localparam int unsigned WIN_LSB = 16 - WIN_W;
  localparam int unsigned NUM_IO  = 3;

  logic mem_ok, io_ok;
  logic unused_low;

  assign unused_low = ^addr_i[3:0];
  assign mem_ok = !is_io_i && write_i && (addr_i[ADDR_W-1:20] == '0);
  assign io_ok  = is_io_i && (addr_i[ADDR_W-1:16] == '0);

  assign hit_o[0] = mem_ok && (addr_i[19:16] == 4'hA);
  assign hit_o[1] = mem_ok && (addr_i[19:15] == 5'b10110);
  assign hit_o[2] = mem_ok && (addr_i[19:15] == 5'b10111);

  // port blocks 0x3B?, 0x3C?, 0x3D?
  for (genvar k = 0; k < NUM_IO; k++) begin : g_io
    assign hit_o[3+k] = io_ok && (addr_i[15:4] == 12'(12'h03B + k));
  end

  assign win_o = addr_i[WIN_LSB +: WIN_W];
endmodule

// File: rtl/vga_smi_regs.sv
module vga_smi_regs
  import vga_smi_pkg::*;
#(
  parameter int unsigned MASK_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            sel_i,
  input  logic [MASK_W-1:0]     wdata_i,
  output logic [NUM_RANGES-1:0] ctrl_o,
  output logic [MASK_W-1:0]     mask_o,
  output logic                  clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      mask_o <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_CTRL) ctrl_o <= wdata_i[NUM_RANGES-1:0];
      if (sel_i == SEL_MASK) mask_o <= wdata_i;
    end
  end

  assign clr_o = we_i && (sel_i == SEL_CLR);
endmodule

// File: rtl/vga_smi_trap.sv
module vga_smi_trap
  import vga_smi_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_is_io_i,
  input  logic              bus_write_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [MASK_W-1:0] cfg_wdata_i,
  output logic              smi_req_o,
  output logic [2:0]        cause_o
);
  localparam int unsigned WIN_W = $clog2(MASK_W);

  logic [NUM_RANGES-1:0] hit, ctrl, eff;
  logic [MASK_W-1:0]     mask;
  logic [WIN_W-1:0]      win;
  logic                  clr, qual;
  logic [CAUSE_W-1:0]    code;
  logic                  smi_q;
  logic [CAUSE_W-1:0]    cause_q;

  vga_smi_decode #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_decode (
    .addr_i (bus_addr_i),
    .is_io_i(bus_is_io_i),
    .write_i(bus_write_i),
    .hit_o  (hit),
    .win_o  (win)
  );

  vga_smi_regs #(.MASK_W(MASK_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .ctrl_o (ctrl),
    .mask_o (mask),
    .clr_o  (clr)
  );

  // window mask gates only the A-segment hit
  always_comb begin
    eff = hit & ctrl;
    eff[HIT_ASEG] = hit[HIT_ASEG] && ctrl[HIT_ASEG] && !mask[win];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (eff[i]) code = CAUSE_W'(i + 1);
  end

  assign qual = bus_valid_i && (eff != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      smi_q <= qual;
      if (qual)     cause_q <= code;
      else if (clr) cause_q <= CAUSE_NONE;
    end
  end

  assign smi_req_o = smi_q;
  assign cause_o   = cause_q;

  a_r1_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> $past(bus_valid_i));

  a_r2_no_read_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_is_io_i && !bus_write_i) |=> !smi_req_o);

  a_r5_masked_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && hit[HIT_ASEG] && mask[win]) |=> !smi_req_o);

  a_r7_cause_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> (cause_o != CAUSE_NONE && cause_o <= CAUSE_P3D));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !bus_valid_i) |=> (cause_o == CAUSE_NONE));

  a_r9_high_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && ((!bus_is_io_i && bus_addr_i[ADDR_W-1:20] != '0) ||
                     (bus_is_io_i && bus_addr_i[ADDR_W-1:16] != '0))) |=> !smi_req_o);
endmodule

// File: tb/vga_smi_trap_tb.sv
module vga_smi_trap_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic        is_io = 1'b0;
  logic        wr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smi;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;
  logic [2:0] model_cause = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_smi_trap u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_addr_i(addr),
    .bus_is_io_i(is_io), .bus_write_i(wr), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .smi_req_o(smi), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd2) model_cause = 3'd0;
  endtask

  // one bus cycle; exp_code 0 means no trap expected
  task automatic access(input logic [31:0] a, input logic io, input logic w,
                        input logic [2:0] exp_code, input string req);
    @(negedge clk);
    valid = 1'b1; addr = a; is_io = io; wr = w;
    @(negedge clk);
    valid = 1'b0;
    if (exp_code != 0) model_cause = exp_code;
    chk({req, " pulse"}, {31'd0, smi}, {31'd0, exp_code != 0});
    chk({req, " cause"}, {29'd0, cause}, {29'd0, model_cause});
  endtask

  task automatic t_reset;
    chk("R11 reset smi", {31'd0, smi}, 32'd0);
    chk("R11 reset cause", {29'd0, cause}, 32'd0);
    access(32'h000A0000, 1'b0, 1'b1, 3'd0, "R11 enables clear");
    access(32'h000003C4, 1'b1, 1'b1, 3'd0, "R11 io enables clear");
  endtask

  task automatic t_mem_write;
    cfg(2'd0, 32'h3F);
    access(32'h000A0000, 1'b0, 1'b1, 3'd1, "R1 aseg low");
    @(negedge clk);
    chk("R1 single clock", {31'd0, smi}, 32'd0);
    access(32'h000AFFFF, 1'b0, 1'b1, 3'd1, "R1 aseg high");
    access(32'h000B0000, 1'b0, 1'b1, 3'd2, "R1 b0 low");
    access(32'h000B7FFF, 1'b0, 1'b1, 3'd2, "R7 b0 high");
    access(32'h000B8000, 1'b0, 1'b1, 3'd3, "R7 b8 low");
    access(32'h000BFFFF, 1'b0, 1'b1, 3'd3, "R1 b8 high");
    access(32'h0009FFFF, 1'b0, 1'b1, 3'd0, "R1 below range");
    access(32'h000C0000, 1'b0, 1'b1, 3'd0, "R7 above range keeps cause");
  endtask

  task automatic t_mem_read;
    access(32'h000A0400, 1'b0, 1'b0, 3'd0, "R2 read aseg");
    access(32'h000B0010, 1'b0, 1'b0, 3'd0, "R2 read b0");
    access(32'h000B8010, 1'b0, 1'b0, 3'd0, "R2 read b8");
  endtask

  task automatic t_io;
    access(32'h000003B0, 1'b1, 1'b0, 3'd4, "R3 io read 3b");
    access(32'h000003CF, 1'b1, 1'b1, 3'd5, "R3 io write 3c");
    access(32'h000003DF, 1'b1, 1'b0, 3'd6, "R3 io read 3d");
    access(32'h000003AF, 1'b1, 1'b1, 3'd0, "R3 io below");
    access(32'h000003E0, 1'b1, 1'b1, 3'd0, "R3 io above");
    access(32'h000003C0, 1'b0, 1'b1, 3'd0, "R3 mem write to port addr");
  endtask

  task automatic t_enables;
    cfg(2'd0, 32'h02);
    access(32'h000A0000, 1'b0, 1'b1, 3'd0, "R4 aseg disabled");
    access(32'h000B0004, 1'b0, 1'b1, 3'd2, "R4 b0 enabled");
    access(32'h000B8004, 1'b0, 1'b1, 3'd0, "R4 b8 disabled");
    cfg(2'd0, 32'h10);
    access(32'h000003B4, 1'b1, 1'b1, 3'd0, "R4 3b disabled");
    access(32'h000003C4, 1'b1, 1'b1, 3'd5, "R4 3c enabled");
    access(32'h000003D4, 1'b1, 1'b1, 3'd0, "R4 3d disabled");
  endtask

  task automatic t_mask;
    cfg(2'd0, 32'h3F);
    cfg(2'd1, 32'h8000_0008);
    access(32'h000A1800, 1'b0, 1'b1, 3'd0, "R5 win3 start");
    access(32'h000A1FFF, 1'b0, 1'b1, 3'd0, "R5 win3 end");
    access(32'h000A17FF, 1'b0, 1'b1, 3'd1, "R5 win2 traps");
    access(32'h000A2000, 1'b0, 1'b1, 3'd1, "R5 win4 traps");
    access(32'h000AF800, 1'b0, 1'b1, 3'd0, "R5 win31");
  endtask

  task automatic t_mask_ignored;
    cfg(2'd1, 32'hFFFF_FFFF);
    access(32'h000B0000, 1'b0, 1'b1, 3'd2, "R6 b0 not masked");
    access(32'h000003D0, 1'b1, 1'b0, 3'd6, "R6 io not masked");
    cfg(2'd0, 32'h3E);
    cfg(2'd1, 32'h0);
    access(32'h000A0800, 1'b0, 1'b1, 3'd0, "R6 aseg off mask zero");
    cfg(2'd0, 32'h3F);
  endtask

  task automatic t_high_bits;
    access(32'h100A0000, 1'b0, 1'b1, 3'd0, "R9 mem bit28");
    access(32'h001B0000, 1'b0, 1'b1, 3'd0, "R9 mem bit20");
    access(32'h000103C0, 1'b1, 1'b1, 3'd0, "R9 io bit16");
  endtask

  task automatic t_back2back;
    @(negedge clk);
    valid = 1'b1; addr = 32'h000A4000; is_io = 1'b0; wr = 1'b1;
    @(negedge clk);
    chk("R10 first pulse", {31'd0, smi}, 32'd1);
    chk("R10 first cause", {29'd0, cause}, 32'd1);
    addr = 32'h000003B8; is_io = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R10 second pulse", {31'd0, smi}, 32'd1);
    chk("R10 second cause", {29'd0, cause}, 32'd4);
    model_cause = 3'd4;
    @(negedge clk);
    chk("R10 pulse ends", {31'd0, smi}, 32'd0);
  endtask

  task automatic t_clear;
    cfg(2'd2, 32'h0);
    chk("R8 clear", {29'd0, cause}, 32'd0);
    @(negedge clk);
    chk("R8 clear sticky", {29'd0, cause}, 32'd0);
    // clear and trap together: trap wins
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2;
    valid = 1'b1; addr = 32'h000B8100; is_io = 1'b0; wr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; valid = 1'b0;
    chk("R8 collide pulse", {31'd0, smi}, 32'd1);
    chk("R8 collide cause", {29'd0, cause}, 32'd3);
    model_cause = 3'd3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_write();
    t_mem_read();
    t_io();
    t_enables();
    t_mask();
    t_mask_ignored();
    t_high_bits();
    t_back2back();
    t_clear();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule